// File: doc/BRIEF.md
# AES-128 Round-Key Expander and Store

This block turns a 128-bit cipher key into the full AES-128 key schedule. The schedule is eleven round keys, or 44 words of 32 bits. A serial generator produces one word per cycle. Each round uses four word slots and one slot in which the finished round is copied into a feedback register. The finished words go into a small word store, which is addressed by a binary write counter.

Once the schedule is complete, the cipher engine reads it one word at a time. Each trigger pulse moves a read pointer. In encrypt mode the pointer walks forward from round 0. In decrypt mode it walks backward through the rounds, starting from round 10. Within a round it always moves upward. One stored schedule therefore serves both directions of the cipher.

Top module: `rkey_sched_store`

## Requirements
- R1: The cycle after a `load` edge, `ready` is low. It rises exactly 55 cycles after that edge, which is 11 rounds of 5 cycles. It then stays high until the next `load`.
- R2: Word 0 of the schedule is `key_in[127:96]` and word 3 is `key_in[31:0]`. Round key 0 is the cipher key itself.
- R3: For r = 1..10, word 4r equals word 4r-4 XOR SubWord(RotWord(word 4r-1)) XOR (rc_r << 24). RotWord moves the top byte to the bottom. The constants rc_1..rc_10 are 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex). With key 2b7e151628aed2a6abf7158809cf4f3c, words 40..43 are d014f9a8, c9ee2589, e13f0cc8, b6630ca6.
- R4: Every other word i ≥ 4 equals word i-1 XOR word i-4.
- R5: If `dir_dec`=0 at `load`, `rk_word` shows word 0 once `ready` is high. Each `step` with `dir_dec`=0 advances to the next word, and a step from word 43 returns to word 0.
- R6: If `dir_dec`=1 at `load`, `rk_word` shows word 40 once `ready` is high. With `dir_dec`=1, a step moves up one word within a round. From the last word of a round it moves to the first word of the previous round. From word 3 it moves to word 40.
- R7: A `step` while `ready` is low has no effect on the read position.
- R8: A `load` while `ready` is high drops `ready` and replaces the stored schedule with the new key's schedule.
- R9: After reset, `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_in | input | 128 | Cipher key, sampled on `load` |
| load | input | 1 | Start expansion; also presets the read position |
| dir_dec | input | 1 | 0 = forward (encrypt) order, 1 = backward round order (decrypt) |
| step | input | 1 | Advance the read position by one word |
| ready | output | 1 | Schedule complete and readable |
| rk_word | output | 32 | Round-key word at the read position; follows a step on the next cycle |

## Verification
The hardest situations to reach are the turns in the read order. These are the jump from the top of one round to the base of the previous round in decrypt mode, and the wrap back to the start after a full pass. The bench reaches them by walking all 44 words in both directions for several keys, then taking one more step. Expansion is hidden inside the block, so every stored word is checked against a schedule the bench computes itself. That computation uses an S-box found by search for the field inverse. The bench also sends a trigger pulse in the middle of every expansion to show the pulse is ignored.

// File: rtl/rks_pkg.sv
package rks_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // GF(2^8) multiply, reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] res;
    pw  = a;
    res = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gf_mul(pw, pw);
      res = gf_mul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] b);
    logic [7:0] v;
    v = gf_inv(b);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  // round constant for round r (1-based)
  function automatic logic [7:0] round_const(input logic [7:0] r);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 1; i < 15; i++) begin
      if (8'(i) < r) c = {c[6:0], 1'b0} ^ (c[7] ? 8'h1b : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/rks_sbox.sv
module rks_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import rks_pkg::*;

  assign dout = sub_byte(din);

endmodule

// File: rtl/rks_expand.sv
module rks_expand
  import rks_pkg::*;
#(
  parameter int NK    = 4,
  parameter int NR    = 10,
  parameter int WORDS = NK * (NR + 1),
  parameter int AW    = $clog2(WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [32*NK-1:0]   key_in,
  input  logic               load,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output word_t              wr_data,
  output logic               ready
);

  localparam int KEY_W = 32 * NK;
  localparam int IW    = $clog2(NK);
  localparam int PW    = $clog2(NK + 1);
  localparam int RW    = $clog2(NR + 1);
  localparam logic [PW-1:0] FILL_PH   = PW'(NK);
  localparam logic [RW-1:0] LAST_RND  = RW'(NR);
  localparam logic [AW-1:0] FULL_ADDR = AW'(WORDS);

  logic              run_q, run_d;
  logic              ready_q, ready_d;
  logic [RW-1:0]     round_q, round_d;
  logic [PW-1:0]     phase_q, phase_d;
  logic [AW-1:0]     waddr_q, waddr_d;
  word_t             prev_q [NK];
  word_t             prev_d [NK];
  word_t             nxt_q  [NK];
  word_t             nxt_d  [NK];

  logic [IW-1:0]     idx, idx_m1;
  word_t             rot_last, sub_rot, new_word;
  logic              slot_word;
  logic              data_en;

  assign idx       = phase_q[IW-1:0];
  assign idx_m1    = idx - IW'(1);
  assign slot_word = (phase_q < FILL_PH);
  assign rot_last  = {prev_q[NK-1][23:0], prev_q[NK-1][31:24]};

  generate
    for (genvar b = 0; b < 4; b++) begin : g_sub
      rks_sbox u_sbox (
        .din  (rot_last[8*b +: 8]),
        .dout (sub_rot[8*b +: 8])
      );
    end
  endgenerate

  // word generator: one word per slot
  always_comb begin
    new_word = prev_q[idx];
    if (round_q != '0) begin
      if (phase_q == '0)
        new_word = prev_q[0] ^ sub_rot ^ {round_const(8'(round_q)), 24'h000000};
      else
        new_word = nxt_q[idx_m1] ^ prev_q[idx];
    end
  end

  // next-state
  always_comb begin
    run_d   = run_q;
    ready_d = ready_q;
    round_d = round_q;
    phase_d = phase_q;
    waddr_d = waddr_q;
    prev_d  = prev_q;
    nxt_d   = nxt_q;
    wr_en   = 1'b0;
    if (load) begin
      run_d   = 1'b1;
      ready_d = 1'b0;
      round_d = '0;
      phase_d = '0;
      waddr_d = '0;
      for (int k = 0; k < NK; k++) prev_d[k] = key_in[KEY_W-1-32*k -: 32];
    end else if (run_q) begin
      if (slot_word) begin
        wr_en      = 1'b1;
        nxt_d[idx] = new_word;
        waddr_d    = waddr_q + AW'(1);
        phase_d    = phase_q + PW'(1);
      end else begin
        prev_d  = nxt_q;
        phase_d = '0;
        if (round_q == LAST_RND) begin
          run_d   = 1'b0;
          ready_d = 1'b1;
        end else begin
          round_d = round_q + RW'(1);
        end
      end
    end
  end

  assign data_en = load | run_q;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ready_q <= 1'b0;
      round_q <= '0;
      phase_q <= '0;
      waddr_q <= '0;
    end else begin
      run_q   <= run_d;
      ready_q <= ready_d;
      round_q <= round_d;
      phase_q <= phase_d;
      waddr_q <= waddr_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (data_en) begin
      prev_q <= prev_d;
      nxt_q  <= nxt_d;
    end
  end

  assign wr_addr = waddr_q;
  assign wr_data = new_word;
  assign ready   = ready_q;

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !load) |=> ready_q);
  // R1
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> (waddr_q == FULL_ADDR));
  // R2
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (waddr_q < FULL_ADDR));
  // R8
  load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!ready_q && run_q));

endmodule

// File: rtl/rks_ram.sv
module rks_ram
  import rks_pkg::*;
#(
  parameter int WORDS = 44,
  parameter int AW    = $clog2(WORDS + 1)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  word_t          wdata,
  input  logic [AW-1:0]  raddr,
  output word_t          rdata
);

  word_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rks_rdptr.sv
module rks_rdptr #(
  parameter int NK    = 4,
  parameter int WORDS = 44,
  parameter int AW    = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dir_dec,
  input  logic          ready,
  input  logic          step,
  output logic [AW-1:0] raddr
);

  localparam int IW = $clog2(NK);
  localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);
  localparam logic [AW-1:0] LAST_BASE = AW'(WORDS - NK);
  localparam logic [AW-1:0] TOP_R0    = AW'(NK - 1);
  localparam logic [AW-1:0] BACK_JUMP = AW'(2 * NK - 1);

  logic [AW-1:0] raddr_q, raddr_d;
  logic          adv;

  assign adv = ready & step;

  always_comb begin
    raddr_d = raddr_q;
    if (load) begin
      raddr_d = dir_dec ? LAST_BASE : '0;
    end else if (adv) begin
      if (!dir_dec)
        raddr_d = (raddr_q == LAST_ADDR) ? '0 : raddr_q + AW'(1);
      else if (raddr_q[IW-1:0] != '1)
        raddr_d = raddr_q + AW'(1);
      else if (raddr_q == TOP_R0)
        raddr_d = LAST_BASE;
      else
        raddr_d = raddr_q - BACK_JUMP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raddr_q <= '0;
    else        raddr_q <= raddr_d;
  end

  assign raddr = raddr_q;

  // R7
  step_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !load) |=> (raddr_q == $past(raddr_q)));
  // R5
  enc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !dir_dec && raddr_q != LAST_ADDR) |=> (raddr_q == $past(raddr_q) + AW'(1)));
  // R6
  dec_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && dir_dec && raddr_q[IW-1:0] == '1 && raddr_q != TOP_R0)
      |=> (raddr_q == $past(raddr_q) - BACK_JUMP));
  // R5
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raddr_q <= LAST_ADDR);

endmodule

// File: rtl/rkey_sched_store.sv
module rkey_sched_store #(
  parameter int NR = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [127:0]  key_in,
  input  logic          load,
  input  logic          dir_dec,
  input  logic          step,
  output logic          ready,
  output logic [31:0]   rk_word
);
  import rks_pkg::*;

  localparam int NK    = 4;
  localparam int WORDS = NK * (NR + 1);
  localparam int AW    = $clog2(WORDS + 1);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  word_t         wr_data;
  logic [AW-1:0] rd_addr;
  word_t         rd_data;
  logic          ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  rks_expand #(.NK(NK), .NR(NR), .WORDS(WORDS), .AW(AW)) u_expand (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .key_in  (key_in),
    .load    (load),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ready   (ready_i)
  );

  rks_ram #(.WORDS(WORDS), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  rks_rdptr #(.NK(NK), .WORDS(WORDS), .AW(AW)) u_rdptr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load    (load),
    .dir_dec (dir_dec),
    .ready   (ready_i),
    .step    (step),
    .raddr   (rd_addr)
  );

  assign ready   = ready_i;
  assign rk_word = rd_data;

  // R9
  rst_ready_chk: assert property (@(posedge clk)
    !core_rst_n |-> !ready_i);

endmodule

// File: tb/tb_rkey_sched_store.sv
module tb_rkey_sched_store;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] key_in;
  logic         load, dir_dec, step;
  logic         ready;
  logic [31:0]  rk_word;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_w [44];
  logic [7:0]  sb [256];

  always #2 clk = ~clk;

  rkey_sched_store dut (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .load(load),
    .dir_dec(dir_dec), .step(step), .ready(ready), .rk_word(rk_word)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = xt(x);
    end
    return r;
  endfunction

  // S-box by searching for the field inverse
  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 8'h00;
      for (int c = 1; c < 256; c++)
        if (mul(8'(v), 8'(c)) == 8'h01) inv = 8'(c);
      sb[v] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
              {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
  endtask

  task automatic build_ref(input logic [127:0] k);
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) exp_w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = exp_w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      exp_w[i] = exp_w[i-4] ^ t;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // load a key, time the expansion, pulse step mid-expansion (must be ignored)
  task automatic do_load(input logic [127:0] k, input logic dec, input string lbl);
    int cnt = 0;
    @(negedge clk);
    key_in = k; dir_dec = dec; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check({"R1/R8 ready low after load ", lbl}, 32'(ready), 32'd0);
    while (!ready && cnt < 200) begin
      step = (cnt == 7) || (cnt == 30);
      @(negedge clk);
      cnt++;
    end
    step = 1'b0;
    check({"R1 expansion latency ", lbl}, 32'(cnt), 32'd55);
  endtask

  task automatic pulse_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] keys [6];
    rst_n = 1'b0; load = 1'b0; step = 1'b0; dir_dec = 1'b0; key_in = '0;
    build_sbox();
    keys[0] = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    keys[1] = '0;
    keys[2] = '1;
    keys[3] = 128'h000102030405060708090a0b0c0d0e0f;
    keys[4] = 128'h80000000000000000000000000000001;
    keys[5] = 128'h6bc1bee22e409f96e93d7e117393172a;
    repeat (3) @(negedge clk);
    check("R9 ready after reset", 32'(ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 ready idle after release", 32'(ready), 32'd0);

    for (int ki = 0; ki < 6; ki++) begin
      build_ref(keys[ki]);
      // forward order (R2 R3 R4 R5 R7)
      do_load(keys[ki], 1'b0, "enc");
      for (int n = 0; n < 44; n++) begin
        check((n < 4) ? "R2 enc word" : ((n % 4 == 0) ? "R3 enc word" : "R4 enc word"),
              rk_word, exp_w[n]);
        pulse_step();
      end
      check("R5 enc wrap to word 0", rk_word, exp_w[0]);
      if (ki == 0) begin
        check("R3 known word 40", exp_w[40], 32'hd014f9a8);
        check("R3 known word 43", exp_w[43], 32'hb6630ca6);
      end
      // backward round order (R6 R7 R8)
      do_load(keys[ki], 1'b1, "dec");
      for (int n = 0; n < 44; n++) begin
        check("R6 dec word", rk_word, exp_w[40 - 4 * (n / 4) + (n % 4)]);
        pulse_step();
      end
      check("R6 dec wrap to word 40", rk_word, exp_w[40]);
    end

    // R8: reload while ready with a different key replaces the schedule
    build_ref(keys[3]);
    do_load(keys[3], 1'b0, "reload");
    check("R8 reloaded word 0", rk_word, exp_w[0]);
    pulse_step();
    check("R8 reloaded word 1", rk_word, exp_w[1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule